// File: doc/BRIEF.md
# Descriptor-Driven Channel Sequencer

This block is one processing channel of a job engine. The host hands it work by writing the address of a descriptor into a small queue. When the channel is idle it takes the oldest queued address and fetches the descriptor it points to: eight 64-bit dwords, read one at a time through a memory request port. It then decodes the header dword, which names the execution unit and its mode and says how completion is reported.

The channel waits until the named unit is free and reserves it. It then requests three transfers, for the key, the context and the data, using addresses held in descriptor dwords 1, 2 and 3. It finishes in one of two ways. The first raises an interrupt pulse. The second writes the header back to the descriptor's own address and then completes without an interrupt. It releases the unit and goes straight on to the next queued address, with no action needed from the host.

Execution units and bus fabric are outside the block. Each is seen only as a valid/ready handshake, a busy vector and a reservation vector.

Top module: `desc_chan_seq`

## Requirements
- R1: After reset, no memory request, transfer request, completion pulse, interrupt or unit reservation is active, and the overflow flag is 0.
- R2: For a descriptor at address P, the channel issues exactly eight reads, one at a time, at P+8*i for i = 0..7 in rising order. A request holds its address until accepted, and each read waits for its response before the next is issued.
- R3: Up to 4 pointers wait in the queue, not counting the descriptor in progress. They are processed strictly in write order.
- R4: A host write that arrives while 4 pointers wait and no pointer leaves in the same cycle is discarded. The overflow flag then reads 1 and stays 1 until reset.
- R5: A host write in the same cycle that a full queue gives up its oldest pointer is accepted. The overflow flag does not set, and that pointer is processed last.
- R6: The header fields are: bits [63:60] give the unit number (bit n of the busy and reservation vectors), bits [59:56] give the mode, and bit 0 is the notify flag. No transfer is requested before all eight dwords have arrived, or while the named unit's busy bit is 1.
- R7: Three transfer requests follow, in order: kind 0 (key) with address dword1[AW-1:0], kind 1 (context) with dword2, and kind 2 (data) with dword3. Each carries the header's unit number and mode and holds until accepted.
- R8: With notify = 1, the channel issues no memory write. Completion is a one-cycle done pulse with the interrupt high in that same cycle.
- R9: With notify = 0, the channel writes the unchanged header to address P and then gives a done pulse with the interrupt low.
- R10: The reservation vector is one-hot on the named unit while transfers or the writeback are in progress, and it is all-zero in the done cycle.
- R11: After a done pulse, if the queue is not empty, the next descriptor fetch starts without host action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host writes a descriptor pointer |
| host_wr_ptr | input | AW | Descriptor address being written |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = header writeback, 0 = descriptor read |
| mem_req_addr | output | AW | Memory request byte address |
| mem_req_wdata | output | 64 | Writeback data (header) |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response dword |
| unit_busy | input | 16 | Per-unit busy flags |
| unit_rsv | output | 16 | Per-unit reservation held by this channel |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_kind | output | 2 | 0 key, 1 context, 2 data |
| xfer_unit | output | 4 | Target unit number |
| xfer_mode | output | 4 | Unit mode from header |
| xfer_addr | output | AW | Source address of the transfer |
| cmpl_pulse | output | 1 | One-cycle descriptor completion |
| cmpl_irq | output | 1 | Interrupt, high with completion when notify = 1 |
| ovf_err | output | 1 | Sticky queue overflow flag |

## Verification
A host write and a queue pop can land in the same cycle. The pop happens in the cycle right after a done pulse. The bench fills the queue while the named unit is held busy, then releases the unit. It watches for the first done pulse and places a host write exactly in the following cycle. The write counts as accepted if the overflow flag stays clear and the extra pointer is fetched and completed last, after the four queued ones.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

  localparam int DWORD_W = 64;
  localparam int DESC_DW = 8;
  localparam int UID_W   = 4;
  localparam int MODE_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDREQ, ST_RDWAIT, ST_WAITU, ST_XFER, ST_WB, ST_DONE
  } chan_st_e;

  typedef enum logic [1:0] {
    XK_KEY  = 2'd0,
    XK_CTX  = 2'd1,
    XK_DATA = 2'd2
  } xfer_kind_e;

  function automatic logic [UID_W-1:0] hdr_unit(input logic [DWORD_W-1:0] h);
    return h[63:60];
  endfunction

  function automatic logic [MODE_W-1:0] hdr_mode(input logic [DWORD_W-1:0] h);
    return h[59:56];
  endfunction

  function automatic logic hdr_notify(input logic [DWORD_W-1:0] h);
    return h[0];
  endfunction

  // byte offset of dword idx inside a descriptor
  function automatic logic [63:0] dword_off(input logic [2:0] idx);
    return {58'd0, idx, 3'b000};
  endfunction

endpackage

// File: rtl/dchan_ptr_fifo.sv
module dchan_ptr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         push_drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign do_pop    = pop && !empty;
  assign do_push   = push && (!full || do_pop);
  assign push_drop = push && full && !do_pop;
  assign dout      = slots[rp];

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R3
  AST_SIMUL_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |=> full); // R5
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> full); // R4

endmodule

// File: rtl/dchan_unit_rsv.sv
module dchan_unit_rsv
  import dchan_pkg::*;
#(
  parameter int NU = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [UID_W-1:0] uid,
  input  logic             done,
  input  logic [NU-1:0]    unit_busy,
  output logic [NU-1:0]    rsv,
  output logic             uid_free
);
  assign uid_free = !unit_busy[uid];

  for (genvar g = 0; g < NU; g++) begin : g_rsv
    assign rsv[g] = hold && (uid == UID_W'(g));
  end

  AST_RSV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsv)); // R10
  AST_RSV_FREE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsv == '0)); // R10

endmodule

// File: rtl/desc_chan_seq.sv
module desc_chan_seq
  import dchan_pkg::*;
#(
  parameter int AW     = 32,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_en,
  input  logic [AW-1:0] host_wr_ptr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [63:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data,
  input  logic [15:0]   unit_busy,
  output logic [15:0]   unit_rsv,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [1:0]    xfer_kind,
  output logic [3:0]    xfer_unit,
  output logic [3:0]    xfer_mode,
  output logic [AW-1:0] xfer_addr,
  output logic          cmpl_pulse,
  output logic          cmpl_irq,
  output logic          ovf_err
);
  localparam int NU = 1 << UID_W;

  chan_st_e          st;
  xfer_kind_e        kind;
  logic [AW-1:0]     cur_ptr;
  logic [2:0]        idx;
  logic [63:0]       dw [DESC_DW];
  logic [AW-1:0]     q_head;
  logic              q_empty, q_full, q_drop;
  logic              uid_free, notify;
  logic [UID_W-1:0]  uid;
  logic [2:0]        xsel;

  // named internal events
  logic ev_fetch_start, ev_dword_cap, ev_fetch_done, ev_unit_grant;
  logic ev_xfer_acc, ev_wb_acc, ev_complete, rsv_hold;

  assign uid    = hdr_unit(dw[0]);
  assign notify = hdr_notify(dw[0]);
  assign xsel   = {1'b0, kind} + 3'd1;

  assign ev_fetch_start = (st == ST_IDLE) && !q_empty;
  assign ev_dword_cap   = (st == ST_RDWAIT) && mem_rsp_valid;
  assign ev_fetch_done  = ev_dword_cap && (idx == 3'd7);
  assign ev_unit_grant  = (st == ST_WAITU) && uid_free;
  assign ev_xfer_acc    = (st == ST_XFER) && xfer_ready;
  assign ev_wb_acc      = (st == ST_WB) && mem_req_ready;
  assign ev_complete    = (st == ST_DONE);
  assign rsv_hold       = (st == ST_XFER) || (st == ST_WB);

  dchan_ptr_fifo #(.W(AW), .DEPTH(QDEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (host_wr_en),
    .din       (host_wr_ptr),
    .pop       (ev_fetch_start),
    .dout      (q_head),
    .empty     (q_empty),
    .full      (q_full),
    .push_drop (q_drop)
  );

  dchan_unit_rsv #(.NU(NU)) u_rsv (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (rsv_hold),
    .uid       (uid),
    .done      (ev_complete),
    .unit_busy (unit_busy),
    .rsv       (unit_rsv),
    .uid_free  (uid_free)
  );

  always_ff @(posedge clk) begin
    if (ev_dword_cap) dw[idx] <= mem_rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= XK_KEY;
      cur_ptr <= '0;
      idx     <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (q_drop) ovf_err <= 1'b1;
      unique case (st)
        ST_IDLE: if (ev_fetch_start) begin
          cur_ptr <= q_head;
          idx     <= '0;
          st      <= ST_RDREQ;
        end
        ST_RDREQ: if (mem_req_ready) st <= ST_RDWAIT;
        ST_RDWAIT: if (ev_dword_cap) begin
          if (ev_fetch_done) st <= ST_WAITU;
          else begin
            idx <= idx + 3'd1;
            st  <= ST_RDREQ;
          end
        end
        ST_WAITU: if (ev_unit_grant) begin
          kind <= XK_KEY;
          st   <= ST_XFER;
        end
        ST_XFER: if (ev_xfer_acc) begin
          if (kind == XK_DATA) st <= notify ? ST_DONE : ST_WB;
          else kind <= xfer_kind_e'(kind + 2'd1);
        end
        ST_WB: if (ev_wb_acc) st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == ST_RDREQ) || (st == ST_WB);
  assign mem_req_write = (st == ST_WB);
  assign mem_req_addr  = (st == ST_WB) ? cur_ptr : cur_ptr + AW'(dword_off(idx));
  assign mem_req_wdata = (st == ST_WB) ? dw[0] : '0;

  assign xfer_valid = (st == ST_XFER);
  assign xfer_kind  = kind;
  assign xfer_unit  = uid;
  assign xfer_mode  = hdr_mode(dw[0]);
  assign xfer_addr  = dw[xsel][AW-1:0];

  assign cmpl_pulse = ev_complete;
  assign cmpl_irq   = ev_complete && notify;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R2
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_kind) && $stable(xfer_addr))); // R7
  AST_WAIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WAITU) && unit_busy[uid]) |=> !xfer_valid); // R6
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_irq |-> cmpl_pulse); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_pulse |=> !cmpl_pulse); // R8
  AST_WB_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_pulse && !cmpl_irq) |-> $past(mem_req_valid && mem_req_write && mem_req_ready)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R4
  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_pulse && !q_empty) |=> ev_fetch_start); // R11

endmodule

// File: tb/sim_desc_chan_seq.sv
`timescale 1ns/1ps
module sim_desc_chan_seq;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr_en = 1'b0;
  logic [AW-1:0] host_wr_ptr = '0;
  logic          mem_req_valid, mem_req_write;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic [63:0]   mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [63:0]   mem_rsp_data = '0;
  logic [15:0]   unit_busy = '0;
  logic [15:0]   unit_rsv;
  logic          xfer_valid, xfer_ready;
  logic [1:0]    xfer_kind;
  logic [3:0]    xfer_unit, xfer_mode;
  logic [AW-1:0] xfer_addr;
  logic          cmpl_pulse, cmpl_irq, ovf_err;

  always #2 clk = ~clk;

  desc_chan_seq #(.AW(AW), .QDEPTH(4)) u0 (.*);

  int compared = 0, mismatched = 0;
  int cyc = 0;
  logic mem_gap = 1'b0, xf_gap = 1'b0;
  logic [63:0] hdr_tab [16];

  assign mem_req_ready = !mem_gap || cyc[1];
  assign xfer_ready    = !xf_gap || cyc[0];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] mem_word(input logic [AW-1:0] a);
    logic [2:0] i;
    i = a[5:3];
    if (i == 3'd0) return hdr_tab[a[9:6]];
    return {32'hD0D0_0000 | 32'(i), a + 32'h1000 * 32'(i)};
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready && !mem_req_write;
    mem_rsp_data  <= mem_word(mem_req_addr);
  end

  // event logs
  logic [AW-1:0] rd_addr [64];  int rd_n;
  logic [AW-1:0] wr_addr [16];  logic [63:0] wr_data [16]; int wr_n;
  logic [1:0]    xf_kind [64];  logic [AW-1:0] xf_addr [64];
  logic [3:0]    xf_unit [64], xf_mode [64]; logic [15:0] xf_rsv [64]; int xf_n;
  logic          dn_irq [16];   logic [15:0] dn_rsv [16]; int dn_n;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        if (!mem_req_write) begin rd_addr[rd_n[5:0]] = mem_req_addr; rd_n++; end
        else begin wr_addr[wr_n[3:0]] = mem_req_addr; wr_data[wr_n[3:0]] = mem_req_wdata; wr_n++; end
      end
      if (xfer_valid && xfer_ready) begin
        xf_kind[xf_n[5:0]] = xfer_kind; xf_addr[xf_n[5:0]] = xfer_addr;
        xf_unit[xf_n[5:0]] = xfer_unit; xf_mode[xf_n[5:0]] = xfer_mode;
        xf_rsv[xf_n[5:0]] = unit_rsv; xf_n++;
      end
      if (cmpl_pulse) begin dn_irq[dn_n[3:0]] = cmpl_irq; dn_rsv[dn_n[3:0]] = unit_rsv; dn_n++; end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; host_wr_en = 1'b0; unit_busy = '0; mem_gap = 1'b0; xf_gap = 1'b0;
    rd_n = 0; wr_n = 0; xf_n = 0; dn_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ptr(input logic [AW-1:0] p);
    @(negedge clk); host_wr_en = 1'b1; host_wr_ptr = p;
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 3000 && dn_n < n; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] pslot(input int s);
    return 32'h0001_0000 + 32'(s) * 32'd64;
  endfunction

  // verify descriptor number d of the current run, at slot s
  task automatic check_desc(input int d, input int s, inout int wi);
    logic [AW-1:0] p;
    logic [63:0] h;
    p = pslot(s); h = hdr_tab[s];
    for (int i = 0; i < 8; i++)
      check("R2 fetch addr", 64'(rd_addr[8*d+i]), 64'(p + 32'(8*i)));
    for (int k = 0; k < 3; k++) begin
      check("R7 xfer kind", 64'(xf_kind[3*d+k]), 64'(k));
      check("R7 xfer addr", 64'(xf_addr[3*d+k]), 64'(p + 32'(8*(k+1)) + 32'h1000 * 32'(k+1)));
      check("R7 xfer unit/mode", {56'd0, xf_unit[3*d+k], xf_mode[3*d+k]}, {56'd0, h[63:56]});
      check("R10 rsv onehot", 64'(xf_rsv[3*d+k]), 64'(16'd1 << h[63:60]));
    end
    check("R10 rsv free at done", 64'(dn_rsv[d]), 64'd0);
    if (h[0]) check("R8 irq with done", 64'(dn_irq[d]), 64'd1);
    else begin
      check("R9 irq low", 64'(dn_irq[d]), 64'd0);
      check("R9 wb addr", 64'(wr_addr[wi]), 64'(p));
      check("R9 wb data", wr_data[wi], h);
      wi++;
    end
  endtask

  task automatic t_reset();
    reset_dut();
    check("R1 idle outputs", {58'd0, mem_req_valid, xfer_valid, cmpl_pulse, cmpl_irq, ovf_err, 1'b0}, 64'd0);
    check("R1 no reservation", 64'(unit_rsv), 64'd0);
  endtask

  task automatic t_irq_single();
    int wi = 0;
    reset_dut(); mem_gap = 1'b1; xf_gap = 1'b1;
    wr_ptr(pslot(1)); wait_done(1);
    check("R2 read count", 64'(rd_n), 64'd8);
    check_desc(0, 1, wi);
    check("R8 no mem write", 64'(wr_n), 64'd0);
  endtask

  task automatic t_wb_single();
    int wi = 0;
    reset_dut();
    wr_ptr(pslot(2)); wait_done(1);
    check_desc(0, 2, wi);
    check("R9 one write", 64'(wr_n), 64'd1);
  endtask

  task automatic t_busy_stall();
    int wi = 0;
    reset_dut();
    unit_busy = 16'd1 << hdr_tab[3][63:60];
    wr_ptr(pslot(3));
    repeat (60) @(negedge clk);
    check("R6 all dwords read", 64'(rd_n), 64'd8);
    check("R6 no xfer while busy", 64'(xf_n), 64'd0);
    check("R6 no reservation while busy", 64'(unit_rsv), 64'd0);
    unit_busy = 16'hFFFF ^ (16'd1 << hdr_tab[3][63:60]);
    wait_done(1);
    check_desc(0, 3, wi);
  endtask

  task automatic t_queue_overflow();
    int wi = 0;
    reset_dut();
    unit_busy = 16'd1 << hdr_tab[4][63:60];
    wr_ptr(pslot(4));
    for (int k = 0; k < 100 && rd_n < 8; k++) @(negedge clk);
    for (int s = 5; s <= 8; s++) wr_ptr(pslot(s));
    check("R4 no ovf at 4 pending", 64'(ovf_err), 64'd0);
    wr_ptr(pslot(9));
    check("R4 ovf set", 64'(ovf_err), 64'd1);
    unit_busy = '0;
    wait_done(5);
    repeat (20) @(negedge clk);
    check("R3 five completions", 64'(dn_n), 64'd5);
    for (int d = 0; d < 5; d++) check_desc(d, 4 + d, wi);
    check("R11 chained fetches", 64'(rd_n), 64'd40);
    check("R4 ovf sticky", 64'(ovf_err), 64'd1);
  endtask

  task automatic t_push_pop_same();
    int wi = 0;
    reset_dut();
    unit_busy = 16'd1 << hdr_tab[10][63:60];
    wr_ptr(pslot(10));
    for (int k = 0; k < 100 && rd_n < 8; k++) @(negedge clk);
    for (int s = 11; s <= 14; s++) wr_ptr(pslot(s));
    unit_busy = '0;
    for (int k = 0; k < 500 && !cmpl_pulse; k++) @(negedge clk);
    @(negedge clk);               // cycle in which the queue gives up its head
    host_wr_en = 1'b1; host_wr_ptr = pslot(15);
    @(negedge clk); host_wr_en = 1'b0;
    wait_done(6);
    repeat (20) @(negedge clk);
    check("R5 ovf clear", 64'(ovf_err), 64'd0);
    check("R5 six completions", 64'(dn_n), 64'd6);
    for (int d = 0; d < 6; d++) check_desc(d, 10 + d, wi);
  endtask

  logic fin = 1'b0;
  initial begin
    for (int s = 0; s < 16; s++)
      hdr_tab[s] = {4'(s * 5 + 1), 4'(s ^ 4'h9), 55'(s * 131), 1'(s % 2)};
    t_reset();
    t_irq_single();
    t_wb_single();
    t_busy_stall();
    t_queue_overflow();
    t_push_pop_same();
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule